// File: doc/BRIEF.md
# Correlated Stochastic Bitstream Pair Generator

This block turns two k-bit binary probabilities into a pair of stochastic bitstreams, X and Y, one bit of each per enabled clock. A stream bit is 1 when a pseudo-random number is below the binary value, so a stream carrying value N has a density of ones close to N/2^k. X is always produced from the first random source. For Y, the block selects one of several random sources, so the pair can be made fully correlated, fully anti-correlated, independent, or a per-cycle blend of these.

Three internal maximal-length LFSRs supply the random numbers. A `start` pulse loads their seeds. An `en` input advances them and emits one registered bit pair, with `valid` marking each emitted pair. The sign input picks positive or negative correlation. The magnitude input sets how often the correlated source is used instead of the independent second LFSR. A third LFSR, compared against the magnitude, makes that choice each cycle. Downstream stochastic gates, such as an XOR used as an absolute-difference unit or an OR used as a saturating adder, rely on the correlation that this block sets.

Top module: `scc_pair_gen`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `x_bit`, `y_bit` and `valid` are 0.
- R2: The sources are 8-bit Fibonacci LFSRs. Each shifts left, and the feedback bit is the XOR of state bits 7, 5, 4 and 3, entering at bit 0. `start` loads `seed_a`, `seed_b` and `seed_c` into sources 1, 2 and 3, and an all-zero seed loads the value 1 instead. A source advances only on a cycle with `en`=1 and `start`=0. A source state is never zero.
- R3: On an enabled cycle, the registered `x_bit` is 1 exactly when source 1 is below `px`. Over one full 255-cycle period, `x_bit` has `px`-1 ones for `px`≥1.
- R4: With `corr_neg`=0 and `corr_mag`=255, Y is compared using source 1 itself. For `px`=`py`, `x_bit` equals `y_bit` on every cycle.
- R5: With `corr_neg`=1 and `corr_mag`=255, Y is compared using the bitwise complement of source 1. When `px`+`py`≤256, `x_bit` and `y_bit` are never both 1.
- R6: With `corr_mag`=0, Y is always compared using source 2.
- R7: With `corr_mag` between 1 and 254, Y uses the correlated source (source 1, or its complement when `corr_neg`=1) on cycles where source 3 is below `corr_mag`, and uses source 2 otherwise.
- R8: `valid` is 1 on the cycle after an edge with `en`=1 and `start`=0, and is 0 otherwise. `start` takes precedence over `en`.
- R9: On cycles that are not enabled, `x_bit` and `y_bit` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load the seeds into the three sources |
| en | input | 1 | Advance the sources and emit one bit pair |
| seed_a | input | 8 | Seed for source 1 (drives X) |
| seed_b | input | 8 | Seed for source 2 (independent source) |
| seed_c | input | 8 | Seed for source 3 (blend selector) |
| px | input | 8 | Binary value encoded on X |
| py | input | 8 | Binary value encoded on Y |
| corr_neg | input | 1 | Correlation sign: 0 positive, 1 negative |
| corr_mag | input | 8 | Correlation magnitude, 0 (none) to 255 (full) |
| x_bit | output | 1 | Registered X stream bit |
| y_bit | output | 1 | Registered Y stream bit |
| valid | output | 1 | The bit pair was produced on the previous enabled cycle |

## Verification
The scoreboard models the three LFSRs and the selection rule and compares every emitted pair. It covers full positive correlation, full negative correlation, zero magnitude, and the blend at magnitudes 1, 128 and 254. Magnitude 1 is a sharp case: source 3 is never zero, so the design must always pick the independent source. A design that compared with the wrong sense, or that treated the full-scale code as a blend, would break bit-for-bit agreement. The bench also covers an all-zero seed, which must not lock a source at zero and stall both streams. A pause must neither advance the sources nor change the outputs, otherwise the stream after the pause slips out of phase. Finally, a `start` pulse held together with `en` must emit nothing, and a full 255-cycle period must give exactly `px`-1 ones on X.

// File: rtl/scc_pkg.sv
package scc_pkg;

   typedef enum logic [1:0] {
      SRC_IND   = 2'b00,
      SRC_POS   = 2'b01,
      SRC_NEG   = 2'b10,
      SRC_SPARE = 2'b11
   } src_sel_e;

   // Feedback masks for left-shifting Fibonacci LFSRs of maximal length.
   function automatic logic [15:0] tap_mask(int unsigned w);
      logic [15:0] m;
      case (w)
         3:       m = 16'h0006;
         4:       m = 16'h000C;
         5:       m = 16'h0014;
         6:       m = 16'h0030;
         7:       m = 16'h0060;
         8:       m = 16'h00B8;
         9:       m = 16'h0110;
         10:      m = 16'h0240;
         11:      m = 16'h0500;
         16:      m = 16'hD008;
         default: m = 16'h0000;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/scc_lfsr.sv
module scc_lfsr #(
   parameter int unsigned     W         = 8,
   parameter logic [W-1:0]    RST_STATE = W'(1)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] seed,
   output logic [W-1:0] state
);
   localparam logic [W-1:0] MASK = W'(scc_pkg::tap_mask(W));

   generate
      if (MASK == '0) begin : g_bad_width
         $error("scc_lfsr: no feedback mask for this width");
      end
      if (RST_STATE == '0) begin : g_bad_rst
         $error("scc_lfsr: reset state must be nonzero");
      end
   endgenerate

   logic [W-1:0] q;
   logic [W-1:0] load_val;
   logic         fb;

   always_comb begin
      load_val = (seed == '0) ? W'(1) : seed;
      fb       = ^(q & MASK);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= RST_STATE;
      end else if (load) begin
         q <= load_val;
      end else if (step) begin
         q <= {q[W-2:0], fb};
      end
   end

   assign state = q;

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
      q != '0); // R2
   AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!load && !step) |=> $stable(q)); // R2

endmodule

// File: rtl/scc_cmp.sv
module scc_cmp #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] rnd,
   input  logic [W-1:0] level,
   output logic         bit_o
);
   assign bit_o = (rnd < level);
endmodule

// File: rtl/scc_src_sel.sv
module scc_src_sel #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] r_corr,
   input  logic [W-1:0] r_ind,
   input  logic [W-1:0] r_mix,
   input  logic         neg,
   input  logic [W-1:0] mag,
   output logic [W-1:0] rnd_y
);
   import scc_pkg::*;

   localparam logic [W-1:0] MAG_FULL = '1;

   logic     use_corr;
   src_sel_e sel;

   always_comb begin
      if (mag == '0) begin
         use_corr = 1'b0;
      end else if (mag >= MAG_FULL) begin
         use_corr = 1'b1;
      end else begin
         use_corr = (r_mix < mag);
      end
      if (!use_corr) begin
         sel = SRC_IND;
      end else if (neg) begin
         sel = SRC_NEG;
      end else begin
         sel = SRC_POS;
      end
   end

   always_comb begin
      unique case (sel)
         SRC_POS:   rnd_y = r_corr;
         SRC_NEG:   rnd_y = ~r_corr;
         SRC_IND:   rnd_y = r_ind;
         default:   rnd_y = r_ind;
      endcase
   end

   always_comb begin
      if (mag == '0) begin
         AST_ZERO_MAG_INDEP: assert (rnd_y == r_ind); // R6
      end
      if (mag == MAG_FULL && !neg) begin
         AST_FULL_POS_SHARED: assert (rnd_y == r_corr); // R4
      end
      if (mag == MAG_FULL && neg) begin
         AST_FULL_NEG_COMPL: assert ((rnd_y ^ r_corr) == MAG_FULL); // R5
      end
   end

endmodule

// File: rtl/scc_pair_gen.sv
module scc_pair_gen #(
   parameter int unsigned K = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         en,
   input  logic [K-1:0] seed_a,
   input  logic [K-1:0] seed_b,
   input  logic [K-1:0] seed_c,
   input  logic [K-1:0] px,
   input  logic [K-1:0] py,
   input  logic         corr_neg,
   input  logic [K-1:0] corr_mag,
   output logic         x_bit,
   output logic         y_bit,
   output logic         valid
);
   localparam int unsigned NSRC = 3;

   generate
      if (K < 3 || K > 16) begin : g_bad_k
         $error("scc_pair_gen: K out of supported range");
      end
   endgenerate

   logic [K-1:0] seeds [NSRC];
   logic [K-1:0] rnd   [NSRC];
   logic         fire;
   logic [K-1:0] rnd_y;
   logic         x_raw;
   logic         y_raw;
   logic         armed;

   assign seeds[0] = seed_a;
   assign seeds[1] = seed_b;
   assign seeds[2] = seed_c;
   assign fire     = en && !start;

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_src
         localparam logic [K-1:0] RST_V = K'(g + 1);
         scc_lfsr #(.W(K), .RST_STATE(RST_V)) u_lfsr (
            .clk   (clk),
            .rst   (rst),
            .load  (start),
            .step  (fire),
            .seed  (seeds[g]),
            .state (rnd[g])
         );
      end
   endgenerate

   scc_src_sel #(.W(K)) u_sel (
      .r_corr (rnd[0]),
      .r_ind  (rnd[1]),
      .r_mix  (rnd[2]),
      .neg    (corr_neg),
      .mag    (corr_mag),
      .rnd_y  (rnd_y)
   );

   scc_cmp #(.W(K)) u_cmp_x (.rnd(rnd[0]), .level(px), .bit_o(x_raw));
   scc_cmp #(.W(K)) u_cmp_y (.rnd(rnd_y),  .level(py), .bit_o(y_raw));

   always_ff @(posedge clk) begin
      if (rst) begin
         x_bit <= 1'b0;
         y_bit <= 1'b0;
         valid <= 1'b0;
         armed <= 1'b0;
      end else begin
         armed <= 1'b1;
         valid <= fire;
         if (fire) begin
            x_bit <= x_raw;
            y_bit <= y_raw;
         end
      end
   end

   AST_VALID_TRACKS_EN: assert property (@(posedge clk) disable iff (rst)
      armed |-> (valid == $past(en && !start))); // R8
   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      (armed && !$past(en && !start)) |-> ($stable(x_bit) && $stable(y_bit))); // R9
   AST_POS_EQUAL: assert property (@(posedge clk) disable iff (rst)
      (armed && valid && $past(!corr_neg && (&corr_mag) && px == py))
      |-> (x_bit == y_bit)); // R4
   AST_NEG_DISJOINT: assert property (@(posedge clk) disable iff (rst)
      (armed && valid && $past(corr_neg && (&corr_mag) &&
         (({1'b0, px} + {1'b0, py}) <= (K+1)'(1 << K))))
      |-> !(x_bit && y_bit)); // R5

endmodule

// File: tb/tb_scc_pair_gen.sv
module tb_scc_pair_gen;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       en = 1'b0;
   logic [7:0] seed_a = '0, seed_b = '0, seed_c = '0;
   logic [7:0] px = '0, py = '0, corr_mag = '0;
   logic       corr_neg = 1'b0;
   logic       x_bit, y_bit, valid;

   int checks = 0;
   int failures = 0;
   int ones_x = 0;
   logic last_x = 1'b0, last_y = 1'b0;
   logic [7:0] m1, m2, m3;
   logic [1:0] exp_q [$];
   string      tag_q [$];

   always #2 clk = ~clk;

   scc_pair_gen dut (
      .clk(clk), .rst(rst), .start(start), .en(en),
      .seed_a(seed_a), .seed_b(seed_b), .seed_c(seed_c),
      .px(px), .py(py), .corr_neg(corr_neg), .corr_mag(corr_mag),
      .x_bit(x_bit), .y_bit(y_bit), .valid(valid)
   );

   function automatic logic [7:0] nxt(logic [7:0] s);
      return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // Monitor: pops expected pairs as the design emits them.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (!rst && valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8", "unexpected valid, queue depth", 0, 1);
            end else begin
               logic [1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk({x_bit, y_bit} == e, t, "xy pair", {x_bit, y_bit}, e);
            end
            ones_x += int'(x_bit);
            last_x = x_bit;
            last_y = y_bit;
         end
      end
   end

   task automatic do_start(logic [7:0] a, logic [7:0] b, logic [7:0] c);
      seed_a = a; seed_b = b; seed_c = c;
      start = 1'b1; en = 1'b0;
      m1 = (a == 0) ? 8'd1 : a;
      m2 = (b == 0) ? 8'd1 : b;
      m3 = (c == 0) ? 8'd1 : c;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Driver: pushes the expected pair for each enabled cycle.
   task automatic run(int n, string tag);
      for (int i = 0; i < n; i++) begin
         logic [7:0] ry;
         logic use_c;
         en = 1'b1;
         if (corr_mag == 0) use_c = 1'b0;
         else if (corr_mag == 8'hFF) use_c = 1'b1;
         else use_c = (m3 < corr_mag);
         ry = use_c ? (corr_neg ? ~m1 : m1) : m2;
         exp_q.push_back({m1 < px, ry < py});
         tag_q.push_back(tag);
         m1 = nxt(m1); m2 = nxt(m2); m3 = nxt(m3);
         @(negedge clk);
      end
      en = 1'b0;
   endtask

   task automatic idle(int n);
      en = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(valid == 1'b0, "R8", "valid while idle", valid, 0);
         chk(x_bit == last_x && y_bit == last_y, "R9", "held xy",
             {x_bit, y_bit}, {last_x, last_y});
      end
   endtask

   initial begin
      #(4 * 150000);
      chk(1'b0, "WATCHDOG", "timeout", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(x_bit == 0 && y_bit == 0 && valid == 0, "R1", "outputs in reset",
          {x_bit, y_bit, valid}, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(x_bit == 0 && y_bit == 0 && valid == 0, "R1", "outputs after reset",
          {x_bit, y_bit, valid}, 0);

      // R4, R3: full positive correlation over one whole period
      px = 8'd100; py = 8'd100; corr_neg = 1'b0; corr_mag = 8'hFF;
      do_start(8'h5A, 8'hC3, 8'h17);
      ones_x = 0;
      run(255, "R4");
      chk(ones_x == 99, "R3", "ones on X over period", ones_x, 99);

      // R5: full negative correlation
      px = 8'd128; py = 8'd128; corr_neg = 1'b1; corr_mag = 8'hFF;
      run(60, "R5");
      px = 8'd40; py = 8'd220;
      run(30, "R5");

      // R6: zero magnitude uses the independent source
      px = 8'd200; py = 8'd60; corr_neg = 1'b0; corr_mag = 8'd0;
      run(60, "R6");

      // R7: blended magnitudes, including both edges of the range
      px = 8'd90; py = 8'd170; corr_mag = 8'd128;
      run(80, "R7");
      corr_neg = 1'b1; corr_mag = 8'd1;
      run(30, "R7");
      corr_mag = 8'd254;
      run(30, "R7");

      // R9, R2: pause must not advance or change outputs
      idle(5);
      run(20, "R2");

      // R2: all-zero seeds are replaced by 1
      px = 8'd10; py = 8'd250; corr_neg = 1'b0; corr_mag = 8'hFF;
      do_start(8'h00, 8'h00, 8'h00);
      run(30, "R2");

      // R3: extreme binary values
      px = 8'd0; py = 8'd255; corr_mag = 8'd0;
      run(20, "R3");

      // R8: start held with en emits nothing
      start = 1'b1; en = 1'b1; seed_a = 8'h33; seed_b = 8'h44; seed_c = 8'h55;
      m1 = 8'h33; m2 = 8'h44; m3 = 8'h55;
      @(negedge clk);
      start = 1'b0; en = 1'b0;
      chk(valid == 1'b0, "R8", "valid with start and en", valid, 0);
      run(10, "R8");

      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R8", "pending items", exp_q.size(), 0);
      finish_run();
   end

endmodule